// File: doc/BRIEF.md
# Transient Blocking Trip Supervisor

This block holds off the trip output of a line protection scheme while an external fault is being cleared and for a short time afterwards. The block forms an arming condition, which is true while the fault detector reports a fault and the trip integrator has not produced an output. The arming condition feeds a pickup/dropout timer. Blocking asserts only after the arming condition has lasted through the whole pickup time. After the condition ends, blocking stays asserted for a separate dropout time. The condition can end because the fault detector resets or because the integrator starts producing an output.

The final trip is the trip request combined with the integrator output, and it is gated by the inverse of blocking. Time is counted in milliseconds from a one-cycle tick enable. Each of the two settings is limited to the range 15 to 99 ms. The fault detector and the trip integrator are outside this block.

Top module: `trip_block_supervisor`

## Requirements
- R1: The arming condition is `fault_det` high with `integ_out` low. Blocking can only rise on a clock edge where this condition holds.
- R2: With `block_active` low, blocking rises on the clock edge that carries the P-th `tick_ms` in an unbroken run of edges where the arming condition is true. P is the effective pickup setting.
- R3: `trip_out` is the combinational AND of `trip_req`, `integ_out` and the inverse of `block_active`. While blocking is asserted, `trip_out` is 0.
- R4: Once the arming condition ends, blocking stays high. It falls on the edge that carries the D-th `tick_ms` in an unbroken run of edges where the condition is false. D is the effective dropout setting.
- R5: An integrator output that appears while the fault flag stays high ends the arming condition. The dropout count then starts just as it does when the fault flag falls.
- R6: If the arming condition returns while blocking is held, blocking stays high and the dropout count clears. The next dropout needs a full D ticks.
- R7: If the arming condition is false on any edge before the pickup completes, the pickup count clears. Blocking then needs a full new run of P ticks.
- R8: Each of `pickup_ms` and `dropout_ms` is a 7-bit unsigned value in milliseconds. A value below 15 acts as 15, and a value above 99 acts as 99.
- R9: Synchronous active-low reset clears both counts and drives `block_active` low on the next edge.
- R10: Only edges with `tick_ms` high advance either count. Edges without a tick leave blocking unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-cycle millisecond enable |
| fault_det | input | 1 | Fault detector flag |
| integ_out | input | 1 | Trip integrator output |
| trip_req | input | 1 | Candidate trip request |
| pickup_ms | input | 7 | Pickup time setting in ms |
| dropout_ms | input | 7 | Dropout time setting in ms |
| trip_out | output | 1 | Gated trip output |
| block_active | output | 1 | Blocking asserted |

## Verification
`block_active` is a register, so it changes on the very edge that samples the P-th or D-th qualifying tick. The bench therefore reads it half a cycle after that edge. `trip_out` has no register in its path: it follows the current inputs and the current blocking state in the same cycle. Inputs change 1 ns after the falling edge, and the compare runs at the falling edge. Every compare therefore sees settled inputs that were applied one rising edge earlier. A behavioural reference model, built on integer counters, is updated on each rising edge and compared against both outputs on every cycle. Directed checks at the boundary ticks confirm the exact cycle in which blocking rises and falls.

// File: rtl/tbs_pkg.sv
// Package: shared widths, setting limits and the clamp helper for the
// transient blocking supervisor. Assumes settings are unsigned millisecond
// counts that fit in SET_W bits.
package tbs_pkg;
    localparam int SET_W   = 7;
    localparam int SET_MIN = 15;
    localparam int SET_MAX = 99;

    typedef logic [SET_W-1:0] set_t;

    // Limit a raw setting to the legal window [lo, hi].
    function automatic set_t clamp_set(input set_t raw, input set_t lo, input set_t hi);
        if (raw < lo)      return lo;
        else if (raw > hi) return hi;
        else               return raw;
    endfunction
endpackage

// File: rtl/tbs_setting_clamp.sv
// Setting limiter: maps a raw millisecond setting into [LO, HI].
// Purely combinational; assumes LO <= HI and both fit in W bits.
module tbs_setting_clamp #(
    parameter int W  = 7,
    parameter int LO = 15,
    parameter int HI = 99
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] eff_o
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    // Select the bounded value.
    always_comb begin
        if (raw_i < LO_V)      eff_o = LO_V;
        else if (raw_i > HI_V) eff_o = HI_V;
        else                   eff_o = raw_i;
    end

    // R8
    always_comb begin
        clamp_range_chk: assert (eff_o >= LO_V && eff_o <= HI_V);
    end
endmodule

// File: rtl/tbs_pu_do_timer.sv
// Pickup/dropout timer: output rises after the input has been true for
// `pickup_i` ticks in a row, and falls after it has been false for
// `dropout_i` ticks in a row. Assumes pickup_i and dropout_i are at least 1
// and that tick_i is a one-cycle enable. Synchronous active-low reset.
module tbs_pu_do_timer #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         arm_i,
    input  logic [W-1:0] pickup_i,
    input  logic [W-1:0] dropout_i,
    output logic         block_o
);
    localparam int CW = W + 1;

    logic [W-1:0]  pu_cnt;
    logic [W-1:0]  do_cnt;
    logic [CW-1:0] pu_next;
    logic [CW-1:0] do_next;

    // Candidate counts after one more qualifying tick.
    always_comb begin
        pu_next = {1'b0, pu_cnt} + CW'(1);
        do_next = {1'b0, do_cnt} + CW'(1);
    end

    // Run the pickup phase while idle and the dropout phase while blocking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            block_o <= 1'b0;
            pu_cnt  <= '0;
            do_cnt  <= '0;
        end else if (!block_o) begin
            do_cnt <= '0;
            if (!arm_i) begin
                pu_cnt <= '0;
            end else if (tick_i) begin
                if (pu_next >= {1'b0, pickup_i}) begin
                    block_o <= 1'b1;
                    pu_cnt  <= '0;
                end else begin
                    pu_cnt <= pu_next[W-1:0];
                end
            end
        end else begin
            pu_cnt <= '0;
            if (arm_i) begin
                do_cnt <= '0;
            end else if (tick_i) begin
                if (do_next >= {1'b0, dropout_i}) begin
                    block_o <= 1'b0;
                    do_cnt  <= '0;
                end else begin
                    do_cnt <= do_next[W-1:0];
                end
            end
        end
    end

    // R1 R2
    assert property (@(posedge clk) disable iff (!rst_n)
        $rose(block_o) |-> $past(arm_i && tick_i))
        else $error("rise_needs_arm_tick_chk");
    // R4
    rise_fall_guard: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(block_o) && $past(rst_n)) |-> $past(!arm_i && tick_i));
    // R6
    hold_while_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (block_o && arm_i) |=> block_o);
    // R10
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(block_o));
    // R7
    pu_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pu_cnt < pickup_i);
endmodule

// File: rtl/tbs_trip_gate.sv
// Final trip gate: trip passes only with request and integrator output
// present and blocking absent. Combinational; no state.
module tbs_trip_gate (
    input  logic trip_req_i,
    input  logic integ_i,
    input  logic block_i,
    output logic trip_o
);
    // Form the gated trip.
    always_comb trip_o = trip_req_i & integ_i & ~block_i;

    // R3
    always_comb begin
        blocked_no_trip_chk: assert (!(block_i && trip_o));
    end
endmodule

// File: rtl/trip_block_supervisor.sv
// Transient blocking trip supervisor: arms a pickup/dropout timer when a
// fault is seen without an integrator output, and uses the timer output to
// inhibit the final trip. Assumes tick_ms is a one-cycle 1 ms enable in the
// clk domain and all inputs are synchronous to clk.
module trip_block_supervisor
    import tbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             fault_det,
    input  logic             integ_out,
    input  logic             trip_req,
    input  logic [SET_W-1:0] pickup_ms,
    input  logic [SET_W-1:0] dropout_ms,
    output logic             trip_out,
    output logic             block_active
);
    localparam int NSET = 2;

    logic             arm;
    logic [SET_W-1:0] raw_set [NSET];
    logic [SET_W-1:0] eff_set [NSET];

    // Arming condition: fault seen and no integrator output.
    always_comb arm = fault_det & ~integ_out;

    // Gather the raw settings for the limiter array.
    always_comb begin
        raw_set[0] = pickup_ms;
        raw_set[1] = dropout_ms;
    end

    // One limiter per timing setting.
    for (genvar g = 0; g < NSET; g++) begin : g_clamp
        tbs_setting_clamp #(
            .W (SET_W),
            .LO(SET_MIN),
            .HI(SET_MAX)
        ) i_clamp (
            .raw_i(raw_set[g]),
            .eff_o(eff_set[g])
        );
    end

    tbs_pu_do_timer #(.W(SET_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_ms),
        .arm_i    (arm),
        .pickup_i (eff_set[0]),
        .dropout_i(eff_set[1]),
        .block_o  (block_active)
    );

    tbs_trip_gate i_gate (
        .trip_req_i(trip_req),
        .integ_i   (integ_out),
        .block_i   (block_active),
        .trip_o    (trip_out)
    );

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> !block_active);
endmodule

// File: tb/test_trip_block_supervisor.sv
module test_trip_block_supervisor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       fault_det = 1'b0;
    logic       integ_out = 1'b0;
    logic       trip_req = 1'b0;
    logic [6:0] pickup_ms = 7'd20;
    logic [6:0] dropout_ms = 7'd30;
    logic       trip_out;
    logic       block_active;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R9";

    // reference model state
    int m_blk = 0;
    int m_pu = 0;
    int m_do = 0;

    always #4 clk = ~clk;

    trip_block_supervisor i_trip_block_supervisor (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .fault_det(fault_det),
        .integ_out(integ_out), .trip_req(trip_req), .pickup_ms(pickup_ms),
        .dropout_ms(dropout_ms), .trip_out(trip_out), .block_active(block_active)
    );

    function automatic int lim(input int v);
        return (v < 15) ? 15 : (v > 99) ? 99 : v;
    endfunction

    // behavioural model, updated on each rising edge
    always @(posedge clk) begin
        bit armed;
        armed = fault_det && !integ_out;
        if (!rst_n) begin
            m_blk = 0; m_pu = 0; m_do = 0;
        end else if (m_blk == 0) begin
            m_do = 0;
            if (!armed) m_pu = 0;
            else if (tick_ms) begin
                m_pu++;
                if (m_pu >= lim(int'(pickup_ms))) begin m_blk = 1; m_pu = 0; end
            end
        end else begin
            m_pu = 0;
            if (armed) m_do = 0;
            else if (tick_ms) begin
                m_do++;
                if (m_do >= lim(int'(dropout_ms))) begin m_blk = 0; m_do = 0; end
            end
        end
    end

    // cycle-by-cycle compare at the falling edge
    always @(negedge clk) begin
        int exp_trip;
        cycles++;
        if (!done) begin
            n_cmp++;
            if (int'(block_active) != m_blk) begin
                n_bad++;
                $display("FAIL %s block_active act=%0d exp=%0d t=%0t", cur_req, block_active, m_blk, $time);
            end
            exp_trip = (trip_req && integ_out && m_blk == 0) ? 1 : 0;
            n_cmp++;
            if (int'(trip_out) != exp_trip) begin
                n_bad++;
                $display("FAIL R3 trip_out act=%0d exp=%0d t=%0t", trip_out, exp_trip, $time);
            end
            if (cycles > 150000) begin
                n_bad++;
                $display("FAIL watchdog act=%0d exp<=150000", cycles);
                done = 1'b1;
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    task automatic step(input bit tk);
        @(negedge clk); #1;
        tick_ms = tk;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            step(1'b1); step(1'b0); step(1'b0);
        end
    endtask

    task automatic expect_blk(input string tag, input bit exp);
        n_cmp++;
        if (block_active !== exp) begin
            n_bad++;
            $display("FAIL %s directed block_active act=%0d exp=%0d", tag, block_active, exp);
        end
    endtask

    task automatic expect_trip(input string tag, input bit exp);
        n_cmp++;
        if (trip_out !== exp) begin
            n_bad++;
            $display("FAIL %s directed trip_out act=%0d exp=%0d", tag, trip_out, exp);
        end
    endtask

    initial begin
        // R9 reset state
        ticks(2);
        expect_blk("R9", 1'b0);
        @(negedge clk); #1; rst_n = 1'b1;

        // R7: 19 ticks then arming drops
        cur_req = "R7";
        fault_det = 1'b1;
        ticks(19);
        expect_blk("R7", 1'b0);
        fault_det = 1'b0;
        ticks(3);
        fault_det = 1'b1;
        ticks(19);
        expect_blk("R7", 1'b0);

        // R2: full pickup run
        cur_req = "R2";
        ticks(1);
        expect_blk("R2", 1'b1);

        // R5/R3: integrator output ends arming while blocked, trip inhibited
        cur_req = "R5";
        integ_out = 1'b1; trip_req = 1'b1;
        step(1'b0);
        expect_trip("R3", 1'b0);
        ticks(29);
        expect_blk("R5", 1'b1);
        ticks(1);
        expect_blk("R4", 1'b0);
        expect_trip("R3", 1'b1);

        // R6: re-arm during dropout restarts the count
        cur_req = "R6";
        integ_out = 1'b0; trip_req = 1'b0;
        ticks(20);
        expect_blk("R6", 1'b1);
        fault_det = 1'b0;
        ticks(10);
        fault_det = 1'b1;
        ticks(2);
        fault_det = 1'b0;
        cur_req = "R4";
        ticks(29);
        expect_blk("R6", 1'b1);
        ticks(1);
        expect_blk("R4", 1'b0);

        // R10: arming with no ticks never blocks
        cur_req = "R10";
        fault_det = 1'b1;
        for (int k = 0; k < 200; k++) step(1'b0);
        expect_blk("R10", 1'b0);
        fault_det = 1'b0;
        step(1'b0);

        // R8: low settings act as 15
        cur_req = "R8";
        pickup_ms = 7'd3; dropout_ms = 7'd0;
        fault_det = 1'b1;
        ticks(14);
        expect_blk("R8", 1'b0);
        ticks(1);
        expect_blk("R8", 1'b1);
        fault_det = 1'b0;
        ticks(14);
        expect_blk("R8", 1'b1);
        ticks(1);
        expect_blk("R8", 1'b0);

        // R8: high setting acts as 99
        pickup_ms = 7'd120;
        fault_det = 1'b1;
        ticks(98);
        expect_blk("R8", 1'b0);
        ticks(1);
        expect_blk("R8", 1'b1);

        // R9: reset while blocked
        cur_req = "R9";
        @(negedge clk); #1; rst_n = 1'b0;
        step(1'b0);
        expect_blk("R9", 1'b0);
        rst_n = 1'b1; fault_det = 1'b0;
        ticks(2);
        expect_blk("R1", 1'b0);

        // R1: integrator high with fault high does not arm
        cur_req = "R1";
        pickup_ms = 7'd15;
        fault_det = 1'b1; integ_out = 1'b1;
        ticks(20);
        expect_blk("R1", 1'b0);

        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule